// File: doc/BRIEF.md
# Event Counter with Compare Match

This block counts events on a conditioned input line and raises a sticky match flag when the running count climbs to a programmed compare value. The input is expected to come from a debounce stage placed in front of it. An event is one edge of that level, by default the rising edge. Events are counted only while the counter function is enabled.

Software reads the count at any time through the count output. It can overwrite the count with a load strobe and step it down by one with a decrement strobe. It can also clear the match flag directly. With a compare value of zero the flag never rises. In that setting the block works as a rate counter that software samples periodically.

Top module: `evt_cmp_counter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `count` is 0 and `match` is 0.
- R2: While `enable` is 1, each 0-to-1 transition of `evt_in` raises `count` by exactly one at the next clock edge. Holding `evt_in` at 1 for several cycles counts once.
- R3: While `enable` is 0, transitions of `evt_in` leave `count` unchanged. Setting `enable` to 1 while `evt_in` is already steady produces no count.
- R4: `count` stops at its maximum value, 2^CNT_W-1. Further events leave it there.
- R5: A one-cycle `dec_stb` lowers `count` by one. At 0 the count stays at 0.
- R6: When an accepted event and `dec_stb` arrive in the same cycle, `count` is unchanged.
- R7: When an accepted event moves `count` to a value equal to a nonzero `cmp_val`, `match` goes to 1 on that clock edge. It then stays 1 until one of the clearing conditions in R9, R10 or R11 occurs.
- R8: With `cmp_val` equal to 0, `match` never rises, whatever the count does.
- R9: A one-cycle `match_clr` sets `match` to 0. If an event sets the flag in the same cycle, `match` is 1 instead.
- R10: A `dec_stb` that leaves `count` below `cmp_val` clears `match`. A decrement that leaves `count` at or above `cmp_val` keeps it.
- R11: `cnt_wr` loads `cnt_wdata` into `count`. The load takes priority over a same-cycle event and over a same-cycle decrement. A load never sets `match`. A load below `cmp_val` clears `match`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Counter function enable |
| evt_in | input | 1 | Conditioned event level from the debounce stage |
| cmp_val | input | CNT_W | Compare value; 0 selects rate-counter mode |
| cnt_wr | input | 1 | Load strobe for the count |
| cnt_wdata | input | CNT_W | Value to load into the count |
| dec_stb | input | 1 | Decrement-by-one strobe |
| match_clr | input | 1 | Clear strobe for the match flag |
| count | output | CNT_W | Current count |
| match | output | 1 | Sticky compare-match flag |

## Verification
The bench builds the block with CNT_W = 4, so the count tops out at 15. With that width it can sweep every compare value from 0 to 15. For each one it drives seventeen events, which carries the count through the match point and into saturation. The expected count and flag at every step come from a closed-form rule. The small width also puts the floor at zero, the ceiling and the collisions between strobes only a few cycles apart.

// File: rtl/evc_pkg.sv
package evc_pkg;
   // Per-cycle operation request seen by the count and match stages.
   typedef struct packed {
      logic inc;   // accepted event
      logic dec;   // software decrement
      logic wr;    // software load
   } evc_op_t;
endpackage

// File: rtl/evc_edge.sv
module evc_edge #(
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   input  logic enable,
   output logic pulse
);
   logic prev_q;
   logic edge_seen;

   // Track the level always, so enabling never sees a stale edge.
   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level;
   end

   generate
      if (RISING) begin : g_rise
         assign edge_seen = level & ~prev_q;
      end else begin : g_fall
         assign edge_seen = ~level & prev_q;
      end
   endgenerate

   assign pulse = edge_seen & enable;
endmodule

// File: rtl/evc_count.sv
module evc_count
   import evc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  evc_op_t          op,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] count_q,
   output logic [CNT_W-1:0] count_next
);
   localparam logic [CNT_W-1:0] CNT_MAX  = '1;
   localparam logic [CNT_W-1:0] CNT_ZERO = '0;
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   always_comb begin
      count_next = count_q;
      if (op.wr) begin
         count_next = wdata;
      end else if (op.inc && !op.dec) begin
         if (count_q != CNT_MAX) count_next = count_q + CNT_ONE;
      end else if (op.dec && !op.inc) begin
         if (count_q != CNT_ZERO) count_next = count_q - CNT_ONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) count_q <= CNT_ZERO;
      else        count_q <= count_next;
   end
endmodule

// File: rtl/evc_match.sv
module evc_match
   import evc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  evc_op_t          op,
   input  logic [CNT_W-1:0] count_next,
   input  logic [CNT_W-1:0] cmp,
   input  logic             clr,
   output logic             match_q
);
   logic inc_eff, dec_eff, set_hit, drop_hit;

   assign inc_eff  = op.inc && !op.dec && !op.wr;
   assign dec_eff  = op.dec && !op.inc && !op.wr;
   assign set_hit  = inc_eff && (cmp != '0) && (count_next == cmp);
   assign drop_hit = clr || ((dec_eff || op.wr) && (count_next < cmp));

   always_ff @(posedge clk) begin
      if (!rst_n)        match_q <= 1'b0;
      else if (set_hit)  match_q <= 1'b1;
      else if (drop_hit) match_q <= 1'b0;
   end
endmodule

// File: rtl/evt_cmp_counter.sv
module evt_cmp_counter
   import evc_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter bit EVT_RISING = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             evt_in,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             dec_stb,
   input  logic             match_clr,
   output logic [CNT_W-1:0] count,
   output logic             match
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("evt_cmp_counter: CNT_W must lie in 2..32");
      end
   endgenerate

   logic             evt_pulse;
   logic [CNT_W-1:0] cnt_next;
   evc_op_t          op;

   evc_edge #(.RISING(EVT_RISING)) u_edge (
      .clk(clk), .rst_n(rst_n), .level(evt_in), .enable(enable), .pulse(evt_pulse)
   );

   assign op.inc = evt_pulse;
   assign op.dec = dec_stb;
   assign op.wr  = cnt_wr;

   evc_count #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .op(op), .wdata(cnt_wdata),
      .count_q(count), .count_next(cnt_next)
   );

   evc_match #(.CNT_W(CNT_W)) u_match (
      .clk(clk), .rst_n(rst_n), .op(op), .count_next(cnt_next),
      .cmp(cmp_val), .clr(match_clr), .match_q(match)
   );
endmodule

// File: rtl/evt_cmp_counter_chk.sv
module evt_cmp_counter_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic [CNT_W-1:0] cmp_val,
   input logic             cnt_wr,
   input logic             dec_stb,
   input logic             match_clr,
   input logic [CNT_W-1:0] count,
   input logic             match
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_wr |=> ({1'b0, count} == {1'b0, $past(count)}) ||
                  ({1'b0, count} == {1'b0, $past(count)} + 1'b1) ||
                  ({1'b0, count} + 1'b1 == {1'b0, $past(count)})); // R2

   AST_IDLE_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !dec_stb && !cnt_wr) |=> $stable(count)); // R3

   AST_HOLD_AT_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_MAX && !dec_stb && !cnt_wr) |=> count == CNT_MAX); // R4

   AST_FLOOR_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && dec_stb && !cnt_wr) |=> count == '0); // R5

   AST_STICKY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (match && !match_clr && !dec_stb && !cnt_wr) |=> match); // R7

   AST_RATE_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_val == '0 && !match) |=> !match); // R8

   AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      (match_clr && !enable) |=> !match); // R9
endmodule

bind evt_cmp_counter evt_cmp_counter_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .cmp_val(cmp_val),
   .cnt_wr(cnt_wr), .dec_stb(dec_stb), .match_clr(match_clr),
   .count(count), .match(match)
);

// File: tb/evt_cmp_counter_test.sv
module evt_cmp_counter_test;
   localparam int CLK_PERIOD = 10;
   localparam int W = 4;
   localparam int MAXV = (1 << W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0, evt_in = 1'b0, cnt_wr = 1'b0, dec_stb = 1'b0, match_clr = 1'b0;
   logic [W-1:0] cmp_val = '0, cnt_wdata = '0;
   logic [W-1:0] count;
   logic match;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   evt_cmp_counter #(.CNT_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .evt_in(evt_in),
      .cmp_val(cmp_val), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
      .dec_stb(dec_stb), .match_clr(match_clr), .count(count), .match(match)
   );

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0; evt_in = 1'b0;
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic pulse_evt();
      @(negedge clk); evt_in = 1'b1;
      @(negedge clk); evt_in = 1'b0;
   endtask

   task automatic load(int v);
      @(negedge clk); cnt_wr = 1'b1; cnt_wdata = W'(v);
      @(negedge clk); cnt_wr = 1'b0;
   endtask

   task automatic dec_once();
      @(negedge clk); dec_stb = 1'b1;
      @(negedge clk); dec_stb = 1'b0;
   endtask

   task automatic clr_once();
      @(negedge clk); match_clr = 1'b1;
      @(negedge clk); match_clr = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      check("R1 count in reset", int'(count), 0);
      check("R1 match in reset", int'(match), 0);
      @(negedge clk); rst_n = 1'b1;
      check("R1 count after reset", int'(count), 0);
      check("R1 match after reset", int'(match), 0);

      // Sweep every compare value across the full count range.
      enable = 1'b1;
      for (int c = 0; c <= MAXV; c++) begin
         do_reset();
         cmp_val = W'(c);
         for (int n = 1; n <= MAXV + 2; n++) begin
            pulse_evt();
            check("R2/R4 sweep count", int'(count), (n > MAXV) ? MAXV : n);
            check("R7/R8 sweep match", int'(match), (c != 0 && n >= c) ? 1 : 0);
         end
      end

      // R2: a held level counts once.
      do_reset(); cmp_val = '0;
      @(negedge clk); evt_in = 1'b1;
      repeat (3) @(negedge clk);
      check("R2 held level counts once", int'(count), 1);
      evt_in = 1'b0; @(negedge clk);

      // R3: disabled counter ignores edges; enabling on steady level adds nothing.
      enable = 1'b0;
      repeat (3) pulse_evt();
      check("R3 disabled edges ignored", int'(count), 1);
      @(negedge clk); evt_in = 1'b1;
      @(negedge clk); enable = 1'b1;
      @(negedge clk);
      check("R3 enable on steady high", int'(count), 1);
      evt_in = 1'b0; @(negedge clk);

      // R5: decrement and floor.
      load(2);
      dec_once(); check("R5 decrement 2->1", int'(count), 1);
      dec_once(); check("R5 decrement 1->0", int'(count), 0);
      dec_once(); check("R5 floor at 0", int'(count), 0);

      // R6: event with decrement cancels.
      load(5);
      @(negedge clk); evt_in = 1'b1; dec_stb = 1'b1;
      @(negedge clk); evt_in = 1'b0; dec_stb = 1'b0;
      check("R6 event plus decrement", int'(count), 5);

      // R9: clear, and set wins over clear.
      cmp_val = W'(3);
      load(2); pulse_evt();
      check("R7 reach compare count", int'(count), 3);
      check("R7 reach compare match", int'(match), 1);
      clr_once();
      check("R9 clear match", int'(match), 0);
      check("R9 clear keeps count", int'(count), 3);
      load(2);
      @(negedge clk); evt_in = 1'b1; match_clr = 1'b1;
      @(negedge clk); evt_in = 1'b0; match_clr = 1'b0;
      check("R9 set beats clear", int'(match), 1);

      // R10: decrement clears only below compare.
      dec_once();
      check("R10 dec below compare count", int'(count), 2);
      check("R10 dec below compare match", int'(match), 0);
      load(4); pulse_evt(); // 4 -> 5, not equal 3, so still 0
      check("R7 pass above compare no set", int'(match), 0);
      load(2); pulse_evt(); pulse_evt(); pulse_evt(); // 3 sets, then 5
      check("R7 sticky past compare", int'(match), 1);
      dec_once();
      check("R10 dec staying above keeps", int'(match), 1);

      // R11: load priority and effect on match.
      @(negedge clk); cnt_wr = 1'b1; cnt_wdata = W'(7); evt_in = 1'b1; dec_stb = 1'b1;
      @(negedge clk); cnt_wr = 1'b0; evt_in = 1'b0; dec_stb = 1'b0;
      check("R11 load wins", int'(count), 7);
      load(1);
      check("R11 load below compare clears", int'(match), 0);
      load(3);
      check("R11 load at compare no set", int'(match), 0);
      check("R11 load value", int'(count), 3);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule